// File: doc/BRIEF.md
# Configurable Logic Macrocell

This block is one logic cell of a programmable-logic fabric. It receives a sum-of-products term from the array in front of it, the asynchronous clear and set terms shared by every cell of its block, and a small bundle of clock/gate lines. A static configuration word decides what the cell is: a plain combinational path, a latch that is open while its gate is low, or an edge-triggered flip-flop working as D-type or T-type. The word also picks one of the clock/gate lines and sets whether the result is inverted.

A buried instance (parameter `BURIED` non-zero) has one more use. It can sample a pin value instead of the sum-of-products term and act as an input register or an input latch. The cell drives two signals. `mc_out` goes toward the I/O cell with the polarity setting applied. `mc_fb` goes back to the interconnect and carries the true value before polarity, in every mode, including combinational.

The clock/gate lines are sampled by the fabric clock `clk`. A rising edge of the selected line is seen at the first `clk` edge where that line is high and was low at the previous `clk` edge. The storage bit is cleared by `rst_n`, which models power-up. The shared clear and set terms act on the storage bit at once, without waiting for `clk`.

Top module: `pld_macrocell`

## Requirements
- R1: The configuration word is loaded from `cfg_din` only at a `clk` edge where `cfg_we` is 1, and is held otherwise; a word presented with `cfg_we` low has no effect. Field layout: bits [1:0] mode (00 combinational, 01 latch, 10 register, 11 capture), bit 2 T-type, bit 3 invert, bits [5:4] clock/gate select, bit 6 capture-as-latch.
- R2: In combinational mode `mc_fb` equals `sop` and `mc_out` equals `sop` XOR invert, with no clock delay.
- R3: In register mode with D-type, a rising edge of the selected line stores `sop`; the new value is visible right after the `clk` edge that sees the rise, and a line that stays high stores nothing further.
- R4: In register mode with T-type, a rising edge of the selected line inverts the stored bit when `sop` is 1 and keeps it when `sop` is 0.
- R5: Only the line chosen by the select field acts as clock or gate; edges and levels on the other lines have no effect.
- R6: In latch mode the output follows `sop` while the selected line is low and holds the last value sampled while it was low once the line is high.
- R7: Polarity is applied after the storage bit: `mc_fb` carries the true stored value, `mc_out` its inverse when invert is 1, and T-type toggling acts on the true value.
- R8: The clear term forces the storage bit to 0 immediately and wins over the set term when both are active.
- R9: The set term alone forces the storage bit to 1 immediately.
- R10: While `rst_n` is low the storage bit is 0, so in a storing mode `mc_out` equals the invert setting and `mc_fb` is 0; the configuration word can still be loaded during reset.
- R11: In a buried cell, capture mode with capture-as-latch 0 stores `pin_in` on a rising edge of the selected line and ignores `sop`.
- R12: In a buried cell, capture mode with capture-as-latch 1 passes `pin_in` while the selected line is low and holds it while the line is high, ignoring `sop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that samples the clock/gate lines and the configuration port |
| rst_n | input | 1 | Active-low power-up reset of the storage bit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_din | input | 7 | Configuration word to load |
| sop | input | 1 | Sum-of-products term from the logic array |
| pin_in | input | 1 | Pin value for the capture modes of a buried cell |
| ar_term | input | 1 | Shared asynchronous clear term |
| ap_term | input | 1 | Shared asynchronous set term |
| cg_line | input | 4 | Clock/gate lines, one of which is selected |
| mc_out | output | 1 | Cell result with polarity applied, toward the I/O cell |
| mc_fb | output | 1 | True cell value toward the interconnect |

## Verification
The hardest situation to reach from the ports is the overlap of the two asynchronous terms: the set term already high, the clear term rising between clock edges, and the storage bit expected to fall at once and stay low through the next edge. The stimulus first builds a stored 1 through a normal clock edge. It then changes the clear and set terms half a cycle away from `clk` and samples the outputs before the next edge, so that any result that relies on `clk` instead of the asynchronous path shows up as a wrong value.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam int MC_NUM_CLK = 4;
  localparam int MC_SEL_W   = $clog2(MC_NUM_CLK);
  localparam int MC_CFG_W   = 3 + MC_SEL_W + 2;

  typedef enum logic [1:0] {
    MC_COMB  = 2'b00,
    MC_LATCH = 2'b01,
    MC_REG   = 2'b10,
    MC_CAPT  = 2'b11
  } mode_e;

  // packed from the top bit down: capture-as-latch, select, invert, T, mode
  typedef struct packed {
    logic                cap_latch;
    logic [MC_SEL_W-1:0] csel;
    logic                inv;
    logic                tff;
    mode_e               mode;
  } cfg_t;

  // next state of the flip-flop for one active clock edge
  function automatic logic next_reg(input logic is_t, input logic d, input logic q);
    logic r;
    if (is_t) r = q ^ d;
    else      r = d;
    return r;
  endfunction

  // polarity stage placed after the storage bit
  function automatic logic apply_pol(input logic v, input logic inv);
    return inv ? ~v : v;
  endfunction

endpackage

// File: rtl/mc_cfg_hold.sv
module mc_cfg_hold
  import mc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  cfg_t din,
  output cfg_t cfg
);

  // no reset: the word is written by the configuration port, even during reset
  always_ff @(posedge clk) begin
    if (we) cfg <= din;
  end

  AST_CFG_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg)); // R1

endmodule

// File: rtl/mc_clk_pick.sv
module mc_clk_pick
  import mc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [MC_NUM_CLK-1:0] lines,
  input  logic [MC_SEL_W-1:0]   sel,
  output logic                  sel_level,
  output logic                  sel_rise
);

  logic [MC_NUM_CLK-1:0] line_q;
  logic [MC_NUM_CLK-1:0] rise_vec;

  // previous sample of each line; reset high so a line already high is no edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '1;
    else        line_q <= lines;
  end

  for (genvar g = 0; g < MC_NUM_CLK; g++) begin : g_edge
    assign rise_vec[g] = lines[g] & ~line_q[g];
  end

  assign sel_level = lines[sel];
  assign sel_rise  = rise_vec[sel];

  AST_RISE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rise && $stable(sel)) |=> (!sel_rise || !$stable(sel))); // R3

endmodule

// File: rtl/mc_store.sv
module mc_store
  import mc_pkg::*;
#(
  parameter int BURIED = 1
)(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ar_term,
  input  logic  ap_term,
  input  mode_e mode,
  input  logic  tff,
  input  logic  cap_latch,
  input  logic  sop,
  input  logic  pin_in,
  input  logic  gate_level,
  input  logic  gate_rise,
  output logic  st,
  output logic  core
);

  logic capt_sel;
  logic is_reg;
  logic use_latch;
  logic use_edge;
  logic din;
  logic edge_load;
  logic lat_load;
  logic transparent;
  logic st_next;

  if (BURIED != 0) begin : g_buried
    assign capt_sel = (mode == MC_CAPT);
  end else begin : g_plain
    assign capt_sel = 1'b0;
  end

  assign is_reg    = (mode == MC_REG);
  assign use_latch = (mode == MC_LATCH) | (capt_sel & cap_latch);
  assign use_edge  = is_reg | (capt_sel & ~cap_latch);
  assign din       = capt_sel ? pin_in : sop;
  assign edge_load = use_edge & gate_rise;
  assign lat_load  = use_latch & ~gate_level;

  always_comb begin
    if (edge_load)     st_next = is_reg ? next_reg(tff, din, st) : din;
    else if (lat_load) st_next = din;
    else               st_next = st;
  end

  // power-up reset, then clear over set, then the clocked update
  always_ff @(posedge clk or negedge rst_n or posedge ar_term or posedge ap_term) begin
    if (!rst_n)       st <= 1'b0;
    else if (ar_term) st <= 1'b0;
    else if (ap_term) st <= 1'b1;
    else              st <= st_next;
  end

  // an open latch passes its data unless a shared term holds the bit
  assign transparent = lat_load & ~ar_term & ~ap_term;

  always_comb begin
    if (mode == MC_COMB)  core = sop;
    else if (transparent) core = din;
    else                  core = st;
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ar_term |-> (st == 1'b0)); // R8

  AST_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_term && !ar_term && $past(ap_term) && !$past(ar_term)) |-> (st == 1'b1)); // R9

  AST_REG_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_reg && !gate_rise && !ar_term && !ap_term)
      |=> (ar_term || ap_term || st == $past(st))); // R3

  AST_T_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (is_reg && tff && gate_rise && sop && !ar_term && !ap_term)
      |=> (ar_term || ap_term || st != $past(st))); // R4

  AST_LATCH_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (use_latch && gate_level && !ar_term && !ap_term)
      |=> (ar_term || ap_term || st == $past(st))); // R6

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import mc_pkg::*;
#(
  parameter int BURIED = 1
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [MC_CFG_W-1:0]   cfg_din,
  input  logic                  sop,
  input  logic                  pin_in,
  input  logic                  ar_term,
  input  logic                  ap_term,
  input  logic [MC_NUM_CLK-1:0] cg_line,
  output logic                  mc_out,
  output logic                  mc_fb
);

  cfg_t cfg;
  logic gate_level;
  logic gate_rise;
  logic st;
  logic core;

  mc_cfg_hold u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .din   (cfg_t'(cfg_din)),
    .cfg   (cfg)
  );

  mc_clk_pick u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .lines     (cg_line),
    .sel       (cfg.csel),
    .sel_level (gate_level),
    .sel_rise  (gate_rise)
  );

  mc_store #(.BURIED(BURIED)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .ar_term    (ar_term),
    .ap_term    (ap_term),
    .mode       (cfg.mode),
    .tff        (cfg.tff),
    .cap_latch  (cfg.cap_latch),
    .sop        (sop),
    .pin_in     (pin_in),
    .gate_level (gate_level),
    .gate_rise  (gate_rise),
    .st         (st),
    .core       (core)
  );

  assign mc_fb  = core;
  assign mc_out = apply_pol(core, cfg.inv);

  AST_COMB_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MC_COMB) |-> (mc_fb == sop)); // R2

  AST_STORE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MC_REG) |-> (mc_fb == st)); // R7

endmodule

// File: tb/pld_macrocell_test.sv
`timescale 1ns/100ps
module pld_macrocell_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [6:0] cfg_din;
  logic       sop;
  logic       pin_in;
  logic       ar_term;
  logic       ap_term;
  logic [3:0] cg_line;
  logic       mc_out;
  logic       mc_fb;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pld_macrocell uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_din (cfg_din),
    .sop     (sop),
    .pin_in  (pin_in),
    .ar_term (ar_term),
    .ap_term (ap_term),
    .cg_line (cg_line),
    .mc_out  (mc_out),
    .mc_fb   (mc_fb)
  );

  // row: req[19:16] we[15] cfg[14:8] sop[7] pin[6] lines[5:2] exp_out[1] exp_fb[0]
  localparam int NROWS = 25;
  localparam logic [19:0] ROWS [NROWS] = '{
    {4'd2,  1'b1, 7'h00, 1'b1, 1'b0, 4'b0000, 1'b1, 1'b1}, // R2 comb
    {4'd7,  1'b1, 7'h08, 1'b1, 1'b0, 4'b0000, 1'b0, 1'b1}, // R7 comb inverted
    {4'd1,  1'b1, 7'h02, 1'b1, 1'b0, 4'b0000, 1'b0, 1'b0}, // R1 switch to register
    {4'd3,  1'b0, 7'h02, 1'b1, 1'b0, 4'b0001, 1'b1, 1'b1}, // R3 edge stores 1
    {4'd3,  1'b0, 7'h02, 1'b0, 1'b0, 4'b0001, 1'b1, 1'b1}, // R3 level high, no store
    {4'd5,  1'b0, 7'h02, 1'b0, 1'b0, 4'b0010, 1'b1, 1'b1}, // R5 other line ignored
    {4'd3,  1'b0, 7'h02, 1'b0, 1'b0, 4'b0011, 1'b0, 1'b0}, // R3 edge stores 0
    {4'd4,  1'b1, 7'h16, 1'b1, 1'b0, 4'b0000, 1'b0, 1'b0}, // R4 T on line 1
    {4'd4,  1'b0, 7'h16, 1'b1, 1'b0, 4'b0010, 1'b1, 1'b1}, // R4 toggle up
    {4'd4,  1'b0, 7'h16, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b1},
    {4'd4,  1'b0, 7'h16, 1'b0, 1'b0, 4'b0010, 1'b1, 1'b1}, // R4 sop 0 holds
    {4'd4,  1'b0, 7'h16, 1'b1, 1'b0, 4'b0000, 1'b1, 1'b1},
    {4'd4,  1'b0, 7'h16, 1'b1, 1'b0, 4'b0010, 1'b0, 1'b0}, // R4 toggle down
    {4'd7,  1'b1, 7'h1E, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b0}, // R7 invert stored 0
    {4'd7,  1'b0, 7'h1E, 1'b1, 1'b0, 4'b0010, 1'b0, 1'b1}, // R7 toggle on true value
    {4'd6,  1'b1, 7'h21, 1'b1, 1'b0, 4'b0000, 1'b1, 1'b1}, // R6 latch open
    {4'd6,  1'b0, 7'h21, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0}, // R6 follows
    {4'd6,  1'b0, 7'h21, 1'b1, 1'b0, 4'b0100, 1'b0, 1'b0}, // R6 gate high holds
    {4'd6,  1'b0, 7'h21, 1'b1, 1'b0, 4'b0000, 1'b1, 1'b1}, // R6 open again
    {4'd1,  1'b0, 7'h00, 1'b0, 1'b0, 4'b0100, 1'b1, 1'b1}, // R1 write without strobe
    {4'd11, 1'b1, 7'h03, 1'b0, 1'b1, 4'b0000, 1'b0, 1'b0}, // R11 capture register
    {4'd11, 1'b0, 7'h03, 1'b0, 1'b1, 4'b0001, 1'b1, 1'b1}, // R11 pin stored, sop ignored
    {4'd12, 1'b1, 7'h43, 1'b1, 1'b0, 4'b0000, 1'b0, 1'b0}, // R12 capture latch open
    {4'd12, 1'b0, 7'h43, 1'b1, 1'b1, 4'b0000, 1'b1, 1'b1}, // R12 follows pin
    {4'd12, 1'b0, 7'h43, 1'b0, 1'b0, 4'b0001, 1'b1, 1'b1}  // R12 gate high holds
  };

  task automatic check(input string what, input int req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_din = '0; sop = 1'b0; pin_in = 1'b0;
    ar_term = 1'b0; ap_term = 1'b0; cg_line = '0;

    // R10: configuration loads during reset, storage stays 0
    @(negedge clk); cfg_we = 1'b1; cfg_din = 7'h0A;
    step();
    check("reset out, register inverted", 10, mc_out, 1'b1);
    check("reset fb, register inverted", 10, mc_fb, 1'b0);
    @(negedge clk); cfg_din = 7'h02;
    step();
    check("reset out, register true", 10, mc_out, 1'b0);
    @(negedge clk); cfg_we = 1'b0; rst_n = 1'b1;
    step();

    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      cfg_we  = ROWS[i][15];
      cfg_din = ROWS[i][14:8];
      sop     = ROWS[i][7];
      pin_in  = ROWS[i][6];
      cg_line = ROWS[i][5:2];
      step();
      check($sformatf("row %0d out", i), int'(ROWS[i][19:16]), mc_out, ROWS[i][1]);
      check($sformatf("row %0d fb", i), int'(ROWS[i][19:16]), mc_fb, ROWS[i][0]);
    end

    // R8 / R9: asynchronous clear and set between clock edges
    @(negedge clk); cfg_we = 1'b1; cfg_din = 7'h02; sop = 1'b1; cg_line = 4'b0000;
    step();
    @(negedge clk); cfg_we = 1'b0; cg_line = 4'b0001;
    step();
    check("stored 1 before clear", 3, mc_fb, 1'b1);
    @(negedge clk); ar_term = 1'b1;
    #0.5;
    check("clear acts at once", 8, mc_fb, 1'b0);
    step();
    @(negedge clk); ar_term = 1'b0;
    step();
    check("stays 0 after clear", 8, mc_fb, 1'b0);
    @(negedge clk); ap_term = 1'b1;
    #0.5;
    check("set acts at once", 9, mc_fb, 1'b1);
    @(negedge clk); ar_term = 1'b1;
    #0.5;
    check("clear over set, immediate", 8, mc_fb, 1'b0);
    step();
    check("clear over set, after edge", 8, mc_fb, 1'b0);
    @(negedge clk); ar_term = 1'b0; ap_term = 1'b0;
    step();

    // R10: reset in mid-run clears a stored 1
    @(negedge clk); cfg_we = 1'b1; cfg_din = 7'h0A; cg_line = 4'b0000;
    step();
    @(negedge clk); cfg_we = 1'b0; sop = 1'b1; cg_line = 4'b0001;
    step();
    check("inverted stored 1", 7, mc_out, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    #0.5;
    check("reset out shows invert", 10, mc_out, 1'b1);
    check("reset fb low", 10, mc_fb, 1'b0);
    @(negedge clk); rst_n = 1'b1; cg_line = 4'b0000;
    step();

    // R5: select line 3; lines 0..2 do nothing
    @(negedge clk); cfg_we = 1'b1; cfg_din = 7'h32; sop = 1'b1;
    step();
    @(negedge clk); cfg_we = 1'b0; cg_line = 4'b0111;
    step();
    check("unselected edges ignored", 5, mc_fb, 1'b0);
    @(negedge clk); cg_line = 4'b1111;
    step();
    check("selected line 3 edge", 5, mc_fb, 1'b1);

    finish_run();
  end

endmodule